// File: doc/BRIEF.md
# Stalled-Request Laggard Detector

This block watches the requests that wait in a switch-level queue in front of one cluster of flash modules. It decides which modules are holding the queue back. A request counts as stalled from the cycle it is enqueued until the cycle it is issued to its module. A request that has been issued but has not yet completed no longer counts as stalled. For every module the block keeps the number of stalled requests and the total number of pages those requests carry.

Two detection strategies run side by side. The service-time strategy multiplies each module's stalled page total by a programmable per-page cost, in cycles. It flags the module when the product exceeds a service-level target that is also held in cycles. The occupancy vote runs in the cycle the queue turns full. It compares the stalled counts of all modules and flags the module or modules with the largest count. If all counts lie within a programmable spread, the vote flags every module. When every module is flagged, an escalate output asks the surrounding system to move data to another cluster instead of within this one.

The vote result stays in place while the queue stays full. The mask falls to zero once the queue is no longer full and every service-time product is back at or under the target. With a 250 MHz clock, the default target of 3.3 µs is 825 cycles.

Top module: `laggard_detector`

## Requirements
- R1: A module's stalled count goes up by one on an enqueue to that module and down by one on an issue to that module. Both may happen in the same cycle. Completion events never change it.
- R2: A module's stalled page total goes up by the enqueue page count and down by the issue page count. Every request carries at least one page.
- R3: Bit m of `lag_mask` is set whenever module m's page total times `cfg_page_cost` is strictly greater than `cfg_sla_cyc`. A product equal to the target does not set the bit.
- R4: In the cycle `q_full` rises, and only then, the vote flags every module whose stalled count equals the largest count.
- R5: If the largest count minus the smallest count is at most `cfg_tie_thr` at that moment, the vote flags all modules.
- R6: The vote result is held while `q_full` stays high and is cleared in the first cycle `q_full` is low. `lag_mask` is the OR of the vote result and the service-time bits.
- R7: `escalate` is high exactly when every bit of `lag_mask` is set.
- R8: `lag_mask` and `escalate` are zero after reset. They reflect an event on the clock edge that samples it, using counts that already include that cycle's events.
- R9: Completion events (`done_vld`) have no effect on `lag_mask` or `escalate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_vld | input | 1 | A request enters the queue |
| enq_mod | input | 2 | Target module of the entering request |
| enq_pages | input | 5 | Page count of the entering request |
| iss_vld | input | 1 | A queued request is issued to its module |
| iss_mod | input | 2 | Module of the issued request |
| iss_pages | input | 5 | Page count of the issued request |
| done_vld | input | 1 | An issued request completes |
| done_mod | input | 2 | Module of the completing request |
| q_full | input | 1 | Queue has no free entry after this cycle's events |
| cfg_sla_cyc | input | 16 | Service-level target in cycles |
| cfg_page_cost | input | 8 | Service cycles per page |
| cfg_tie_thr | input | 5 | Largest count spread treated as similar |
| lag_mask | output | 4 | One bit per module flagged as laggard |
| escalate | output | 1 | Every module is a laggard |

## Verification
The bench builds the block with its defaults: four modules, 5-bit counts, 10-bit page totals and page counts up to 31. It models a queue of eight entries. A queue that shallow turns full often under random traffic, so the vote, its hold and its release happen many times, including with issues and enqueues landing on the same module in one cycle. The target is 825 cycles. With the page cost set to 55, a single request of 15 or 16 pages lands exactly on the target or one page past it. With a cost of 25, a few mixed requests are enough to cross the target.

// File: rtl/lagd_pkg.sv
`timescale 1ns/1ps
package lagd_pkg;

  // Estimated service cycles for a page total at a given per-page cost.
  function automatic logic [31:0] svc_time(input logic [31:0] pages,
                                           input logic [31:0] cost);
    return pages * cost;
  endfunction

  // True when the spread between the largest and smallest count is small.
  function automatic logic is_similar(input logic [31:0] hi,
                                      input logic [31:0] lo,
                                      input logic [31:0] thr);
    return (hi - lo) <= thr;
  endfunction

endpackage

// File: rtl/lagd_track.sv
`timescale 1ns/1ps
module lagd_track #(
  parameter int MOD_W = 2,
  parameter int PG_W  = 5,
  parameter int CNT_W = 5,
  parameter int SUM_W = 10,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_vld,
  input  logic [MOD_W-1:0] enq_mod,
  input  logic [PG_W-1:0]  enq_pages,
  input  logic             iss_vld,
  input  logic [MOD_W-1:0] iss_mod,
  input  logic [PG_W-1:0]  iss_pages,
  input  logic             done_vld,
  input  logic [MOD_W-1:0] done_mod,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [SUM_W-1:0] sum_nx
);
  localparam logic [MOD_W-1:0] ME = MOD_W'(IDX);

  logic             enq_hit, iss_hit, done_hit;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] fl_q, fl_nx;

  assign enq_hit  = enq_vld  && (enq_mod  == ME);
  assign iss_hit  = iss_vld  && (iss_mod  == ME);
  assign done_hit = done_vld && (done_mod == ME);

  always_comb begin
    cnt_nx = cnt_q;
    sum_nx = sum_q;
    fl_nx  = fl_q;
    if (enq_hit) begin
      cnt_nx = cnt_nx + CNT_W'(1);
      sum_nx = sum_nx + SUM_W'(enq_pages);
    end
    if (iss_hit) begin
      cnt_nx = cnt_nx - CNT_W'(1);
      sum_nx = sum_nx - SUM_W'(iss_pages);
      fl_nx  = fl_nx + CNT_W'(1);
    end
    if (done_hit) fl_nx = fl_nx - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
      fl_q  <= '0;
    end else begin
      cnt_q <= cnt_nx;
      sum_q <= sum_nx;
      fl_q  <= fl_nx;
    end
  end

  // R1: an issue needs a stalled request for this module
  p_iss_has_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iss_hit |-> (cnt_q != '0) || enq_hit);

  // R2: no stalled requests means no stalled pages
  p_empty_no_pages_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (sum_q == '0));

  // R9: a completion needs an issued request still in flight
  p_done_has_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |-> (fl_q != '0) || iss_hit);

endmodule

// File: rtl/lagd_vote.sv
`timescale 1ns/1ps
module lagd_vote #(
  parameter int N_MOD = 4,
  parameter int CNT_W = 5
) (
  input  logic [N_MOD-1:0][CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0]            thr,
  output logic [N_MOD-1:0]            pick
);
  logic [CNT_W-1:0] hi, lo;
  logic             tie;

  always_comb begin
    hi = cnt[0];
    lo = cnt[0];
    for (int m = 1; m < N_MOD; m++) begin
      if (cnt[m] > hi) hi = cnt[m];
      if (cnt[m] < lo) lo = cnt[m];
    end
  end

  assign tie = lagd_pkg::is_similar(32'(hi), 32'(lo), 32'(thr));

  for (genvar m = 0; m < N_MOD; m++) begin : g_pick
    assign pick[m] = tie || (cnt[m] == hi);
  end

endmodule

// File: rtl/laggard_detector.sv
`timescale 1ns/1ps
module laggard_detector #(
  parameter int N_MOD = 4,
  parameter int PG_W  = 5,
  parameter int CNT_W = 5,
  parameter int SUM_W = 10,
  parameter int TGT_W = 16,
  parameter int CST_W = 8,
  localparam int MOD_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_vld,
  input  logic [MOD_W-1:0] enq_mod,
  input  logic [PG_W-1:0]  enq_pages,
  input  logic             iss_vld,
  input  logic [MOD_W-1:0] iss_mod,
  input  logic [PG_W-1:0]  iss_pages,
  input  logic             done_vld,
  input  logic [MOD_W-1:0] done_mod,
  input  logic             q_full,
  input  logic [TGT_W-1:0] cfg_sla_cyc,
  input  logic [CST_W-1:0] cfg_page_cost,
  input  logic [CNT_W-1:0] cfg_tie_thr,
  output logic [N_MOD-1:0] lag_mask,
  output logic             escalate
);
  logic [N_MOD-1:0][CNT_W-1:0] cnt_nx;
  logic [N_MOD-1:0][SUM_W-1:0] sum_nx;
  logic [N_MOD-1:0]            sla_n, pick, vote_n;
  logic [N_MOD-1:0]            sla_q, vote_q;
  logic                        full_d, full_rise, esc_q;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    lagd_track #(
      .MOD_W(MOD_W), .PG_W(PG_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX(m)
    ) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .enq_vld  (enq_vld),
      .enq_mod  (enq_mod),
      .enq_pages(enq_pages),
      .iss_vld  (iss_vld),
      .iss_mod  (iss_mod),
      .iss_pages(iss_pages),
      .done_vld (done_vld),
      .done_mod (done_mod),
      .cnt_nx   (cnt_nx[m]),
      .sum_nx   (sum_nx[m])
    );
    assign sla_n[m] = lagd_pkg::svc_time(32'(sum_nx[m]), 32'(cfg_page_cost))
                      > 32'(cfg_sla_cyc);
  end

  lagd_vote #(.N_MOD(N_MOD), .CNT_W(CNT_W)) i_vote (
    .cnt (cnt_nx),
    .thr (cfg_tie_thr),
    .pick(pick)
  );

  assign full_rise = q_full && !full_d;

  always_comb begin
    if (!q_full)        vote_n = '0;
    else if (full_rise) vote_n = pick;
    else                vote_n = vote_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_d <= 1'b0;
      vote_q <= '0;
      sla_q  <= '0;
      esc_q  <= 1'b0;
    end else begin
      full_d <= q_full;
      vote_q <= vote_n;
      sla_q  <= sla_n;
      esc_q  <= &(vote_n | sla_n);
    end
  end

  assign lag_mask = vote_q | sla_q;
  assign escalate = esc_q;

  // R6: a vote result exists only while the queue was full
  p_vote_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_q != '0) |-> full_d);

  // R6: a held vote does not change while the queue stays full
  p_vote_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_d && q_full) |=> $stable(vote_q));

  // R7: escalate agrees with a completely set mask
  p_esc_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    escalate == ($countones(lag_mask) == N_MOD));

  // R4: a fresh vote never comes out empty
  p_vote_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_rise |=> (vote_q != '0));

endmodule

// File: tb/test_laggard_detector.sv
`timescale 1ns/1ps
module test_laggard_detector;
  localparam int N  = 4;
  localparam int QD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enq_vld, iss_vld, done_vld, q_full;
  logic [1:0] enq_mod, iss_mod, done_mod;
  logic [4:0] enq_pages, iss_pages;
  logic [15:0] cfg_sla_cyc;
  logic [7:0]  cfg_page_cost;
  logic [4:0]  cfg_tie_thr;
  logic [3:0]  lag_mask;
  logic        escalate;

  always #2 clk = ~clk;

  laggard_detector i_laggard_detector (
    .clk(clk), .rst_n(rst_n),
    .enq_vld(enq_vld), .enq_mod(enq_mod), .enq_pages(enq_pages),
    .iss_vld(iss_vld), .iss_mod(iss_mod), .iss_pages(iss_pages),
    .done_vld(done_vld), .done_mod(done_mod), .q_full(q_full),
    .cfg_sla_cyc(cfg_sla_cyc), .cfg_page_cost(cfg_page_cost),
    .cfg_tie_thr(cfg_tie_thr), .lag_mask(lag_mask), .escalate(escalate)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_cnt[N], m_sum[N], m_fl[N];
  int pq[N][$];
  bit [3:0] m_vote;
  bit m_prev_full;

  function automatic bit [3:0] exp_vote();
    int hi = m_cnt[0], lo = m_cnt[0];
    bit [3:0] r;
    for (int m = 1; m < N; m++) begin
      if (m_cnt[m] > hi) hi = m_cnt[m];
      if (m_cnt[m] < lo) lo = m_cnt[m];
    end
    for (int m = 0; m < N; m++)
      r[m] = ((hi - lo) <= int'(cfg_tie_thr)) || (m_cnt[m] == hi);
    return r;
  endfunction

  function automatic bit [3:0] exp_mask();
    bit [3:0] r = m_vote;
    for (int m = 0; m < N; m++)
      if (m_sum[m] * int'(cfg_page_cost) > int'(cfg_sla_cyc)) r[m] = 1'b1;
    return r;
  endfunction

  function automatic int total();
    int t = 0;
    for (int m = 0; m < N; m++) t += m_cnt[m];
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one cycle of events, then checks the outputs after the edge.
  task automatic step(input bit e, input int em, input int ep,
                      input bit i, input int im, input bit d, input int dm,
                      input string req);
    bit full;
    bit [3:0] em_exp;
    int ip = 0;
    if (i) ip = pq[im].pop_front();
    enq_vld = e; enq_mod = 2'(em); enq_pages = 5'(ep);
    iss_vld = i; iss_mod = 2'(im); iss_pages = 5'(ip);
    done_vld = d; done_mod = 2'(dm);
    if (e) begin m_cnt[em]++; m_sum[em] += ep; pq[em].push_back(ep); end
    if (i) begin m_cnt[im]--; m_sum[im] -= ip; m_fl[im]++; end
    if (d) m_fl[dm]--;
    full = (total() == QD);
    q_full = full;
    if (!full) m_vote = '0;
    else if (!m_prev_full) m_vote = exp_vote();
    m_prev_full = full;
    em_exp = exp_mask();
    @(posedge clk);
    @(negedge clk);
    enq_vld = 0; iss_vld = 0; done_vld = 0;
    check({req, " mask"}, int'(lag_mask), int'(em_exp));
    check({req, " escalate (R7)"}, int'(escalate), int'(em_exp == 4'hF));
  endtask

  task automatic idle(input string req);
    step(0, 0, 1, 0, 0, 0, 0, req);
  endtask

  task automatic drain();
    for (int m = 0; m < N; m++)
      while (m_cnt[m] > 0) step(0, 0, 1, 1, m, 0, 0, "drain R6");
    for (int m = 0; m < N; m++)
      while (m_fl[m] > 0) step(0, 0, 1, 0, 0, 1, m, "drain R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit [3:0] hold;
    void'($urandom(32'd4242));
    rst_n = 0; enq_vld = 0; iss_vld = 0; done_vld = 0; q_full = 0;
    enq_mod = 0; iss_mod = 0; done_mod = 0; enq_pages = 0; iss_pages = 0;
    cfg_sla_cyc = 16'd825; cfg_page_cost = 8'd55; cfg_tie_thr = 5'd1;
    for (int m = 0; m < N; m++) begin m_cnt[m] = 0; m_sum[m] = 0; m_fl[m] = 0; end
    m_vote = '0; m_prev_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset mask", int'(lag_mask), 0);
    check("R8 reset escalate", int'(escalate), 0);

    // R3: exactly on target is not a laggard, one page over is
    step(1, 0, 15, 0, 0, 0, 0, "R3 equal target");
    check("R3 m0 clear at 825", int'(lag_mask[0]), 0);
    step(1, 0, 1, 0, 0, 0, 0, "R3 over target");
    check("R3 m0 set at 880", int'(lag_mask[0]), 1);
    step(0, 0, 1, 1, 0, 0, 0, "R2 issue drops pages");
    check("R2 m0 clear after issue", int'(lag_mask[0]), 0);
    step(1, 0, 20, 1, 0, 0, 0, "R1 R2 same-cycle enq and issue");
    drain();

    // R9: completion while another module is flagged changes nothing
    step(1, 1, 3, 0, 0, 0, 0, "R9 setup");
    step(0, 0, 1, 1, 1, 0, 0, "R9 issue");
    step(1, 2, 16, 0, 0, 0, 0, "R9 flag m2");
    hold = lag_mask;
    step(0, 0, 1, 0, 0, 1, 1, "R9 completion");
    check("R9 mask unchanged by completion", int'(lag_mask), int'(hold));
    drain();

    // R4/R6: dominant module wins the vote, held while full, dropped after
    cfg_page_cost = 8'd1;
    for (int k = 0; k < 5; k++) step(1, 2, 1, 0, 0, 0, 0, "R4 fill");
    step(1, 0, 1, 0, 0, 0, 0, "R4 fill");
    step(1, 1, 1, 0, 0, 0, 0, "R4 fill");
    step(1, 3, 1, 0, 0, 0, 0, "R4 vote at full");
    check("R4 only m2 flagged", int'(lag_mask), 4'b0100);
    idle("R6 hold while full");
    check("R6 vote held", int'(lag_mask), 4'b0100);
    step(0, 0, 1, 1, 0, 0, 0, "R6 drop below full");
    check("R6 vote cleared", int'(lag_mask), 0);
    drain();

    // R5/R7: balanced counts flag every module and escalate
    for (int k = 0; k < 8; k++) step(1, k % 4, 2, 0, 0, 0, 0, "R5 balanced fill");
    check("R5 all flagged", int'(lag_mask), 4'hF);
    check("R7 escalate on all", int'(escalate), 1);
    drain();

    // R5: spread of two with threshold one picks only the top module
    for (int k = 0; k < 3; k++) step(1, 0, 1, 0, 0, 0, 0, "R5 spread fill");
    for (int k = 0; k < 2; k++) step(1, 1, 1, 0, 0, 0, 0, "R5 spread fill");
    for (int k = 0; k < 2; k++) step(1, 2, 1, 0, 0, 0, 0, "R5 spread fill");
    step(1, 3, 1, 0, 0, 0, 0, "R5 spread vote");
    check("R5 spread above threshold", int'(lag_mask), 4'b0001);
    drain();

    // Random mixed traffic against the bench model
    cfg_page_cost = 8'd25;
    for (int c = 0; c < 4000; c++) begin
      bit e, i, d;
      int em, ep, im, dm;
      e = (total() < QD) && ($urandom % 2 == 0);
      em = ($urandom % 3 == 0) ? 0 : int'($urandom % 4);
      ep = 1 + int'($urandom % 8);
      i = 0; im = 0;
      if (total() > 0 && ($urandom % 3 != 0)) begin
        im = int'($urandom % 4);
        while (m_cnt[im] == 0) im = (im + 1) % N;
        i = 1;
      end
      d = 0; dm = int'($urandom % 4);
      for (int k = 0; k < N; k++)
        if (!d && m_fl[(dm + k) % N] > 0 && ($urandom % 2 == 0)) begin
          d = 1; dm = (dm + k) % N;
        end
      if (c % 500 == 0) cfg_tie_thr = 5'($urandom % 3);
      step(e, em, ep, i, im, d, dm, "R1 R3 R4 R5 R6 random");
    end
    drain();
    check("R6 mask clear after drain", int'(lag_mask), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule